// File: doc/BRIEF.md
# Three-Register GPIO Port

An eight-pin general-purpose I/O port whose per-pin control and status live in three registers at separate addresses: a direction register, an output/pull-up latch, and a read-only register that holds the pin levels. A simple register bus reaches these registers. It has a two-bit address, a write enable, write data and read data. Reads are combinational from the currently selected address. Writes take effect on the rising clock edge.

On the pad side the block drives an output enable, an output value and a pull-up enable for each pin. A pin with its direction bit set drives its latch bit push-pull. A pin with its direction bit clear uses its latch bit as the pull-up enable. With both bits clear the pin floats and its pull-up is off. The incoming pin levels pass through a two-flop synchronizer before software can read them.

The latch and the pin levels sit at different addresses. Software can therefore read the latch, change some bits and write it back. This never copies pin levels into the latch, and a pull-up on an input that happens to read low is never switched off.

Top module: `gpio_tri_port`

## Requirements
- R1: While reset is asserted, and right after it is released, the direction and latch registers are zero. All of pin_oe_o, pin_out_o and pin_pu_o are 0, and reads of addresses 0 and 1 return 0.
- R2: A write to address 0 loads the direction register on the clock edge. A read of address 0 returns the direction register.
- R3: A write to address 1 loads the latch on the clock edge. A read of address 1 returns the latch contents, whatever the pin levels are.
- R4: A pin with direction bit 1 has pin_oe_o=1, pin_out_o equal to its latch bit, and pin_pu_o=0.
- R5: A pin with direction bit 0 has pin_oe_o=0, pin_out_o=0, and pin_pu_o equal to its latch bit. With both bits 0 the pin is tri-stated and its pull-up is off.
- R6: A read of address 2 returns pin_i passed through two flip-flops. A level present before clock edge k is returned after edge k+1 and not after edge k.
- R7: Writes to address 2 and address 3 change neither the direction register nor the latch. A read of address 3 returns 0.
- R8: Each pin's direction and pull-up are controlled by its own bits, with no effect on other pins.
- R9: Read-modify-write on the latch keeps the pull-up setting of every input pin, including inputs whose pin level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 direction, 1 latch, 2 pin level, 3 unused |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pin_i | input | 8 | External pin levels, asynchronous |
| pin_oe_o | output | 8 | Output enable per pin |
| pin_out_o | output | 8 | Output value per pin |
| pin_pu_o | output | 8 | Pull-up enable per pin |

## Verification
Register writes become visible on the read path and the pad outputs after one clock edge. The bench applies each write half a cycle before an edge and samples at the following falling edge. A pin-level change needs two edges to reach address 2. The bench therefore expects each read of address 2 to return the pin value from the step before. A directed test samples after the first edge, where the old value is still expected, and again after the second edge, where the new value must appear. Reset checks are made while reset is still asserted, because the reset is asynchronous and needs no edge to take effect.

// File: rtl/gpio_tri_pkg.sv
package gpio_tri_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_LAT  = 2'd1,
    REG_LVL  = 2'd2,
    REG_NONE = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_tri_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [PIN_W-1:0]      wdata_i,
  output logic [PIN_W-1:0]      dir_o,
  output logic [PIN_W-1:0]      lat_o
);
  logic dir_wr, lat_wr;

  assign dir_wr = we_i && (addr_i == REG_DIR);
  assign lat_wr = we_i && (addr_i == REG_LAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      lat_o <= '0;
    end else begin
      if (dir_wr) dir_o <= wdata_i;
      if (lat_wr) lat_o <= wdata_i;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] pin_i,
  output logic [PIN_W-1:0] lvl_o
);
  for (genvar g = 0; g < PIN_W; g++) begin : g_pin
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], pin_i[g]};
    end

    assign lvl_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned PIN_W = 8
) (
  input  logic [PIN_W-1:0] dir_i,
  input  logic [PIN_W-1:0] lat_i,
  output logic [PIN_W-1:0] oe_o,
  output logic [PIN_W-1:0] out_o,
  output logic [PIN_W-1:0] pu_o
);
  for (genvar g = 0; g < PIN_W; g++) begin : g_pad
    // driven pins never enable pull-up; undriven pins hold output low
    assign oe_o[g]  = dir_i[g];
    assign out_o[g] = dir_i[g] & lat_i[g];
    assign pu_o[g]  = ~dir_i[g] & lat_i[g];
  end
endmodule

// File: rtl/gpio_tri_port.sv
module gpio_tri_port
  import gpio_tri_pkg::*;
#(
  parameter int unsigned PIN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  we_i,
  input  logic [PIN_W-1:0]      wdata_i,
  output logic [PIN_W-1:0]      rdata_o,
  input  logic [PIN_W-1:0]      pin_i,
  output logic [PIN_W-1:0]      pin_oe_o,
  output logic [PIN_W-1:0]      pin_out_o,
  output logic [PIN_W-1:0]      pin_pu_o
);
  logic [PIN_W-1:0] dir_q, lat_q, lvl_q;

  gpio_ctrl_regs #(.PIN_W(PIN_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .dir_o   (dir_q),
    .lat_o   (lat_q)
  );

  gpio_in_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl_q)
  );

  gpio_pad_ctrl #(.PIN_W(PIN_W)) u_pad (
    .dir_i (dir_q),
    .lat_i (lat_q),
    .oe_o  (pin_oe_o),
    .out_o (pin_out_o),
    .pu_o  (pin_pu_o)
  );

  // latch and pin levels kept apart so read-modify-write sees the latch
  always_comb begin
    unique case (addr_i)
      REG_DIR: rdata_o = dir_q;
      REG_LAT: rdata_o = lat_q;
      REG_LVL: rdata_o = lvl_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_tri_port_chk.sv
module gpio_tri_port_chk
  import gpio_tri_pkg::*;
#(
  parameter int unsigned PIN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [REG_ADDR_W-1:0] addr_i,
  input logic                  we_i,
  input logic [PIN_W-1:0]      wdata_i,
  input logic [PIN_W-1:0]      rdata_o,
  input logic [PIN_W-1:0]      pin_i,
  input logic [PIN_W-1:0]      pin_oe_o,
  input logic [PIN_W-1:0]      pin_out_o,
  input logic [PIN_W-1:0]      pin_pu_o
);
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert ((pin_oe_o | pin_out_o | pin_pu_o) == '0);
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DIR) |=> (pin_oe_o == $past(wdata_i)));

  // R3
  lat_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_LAT) |=> ((pin_out_o | pin_pu_o) == $past(wdata_i)));

  // R4
  no_pu_on_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pu_o & pin_oe_o) == '0);

  // R5
  no_out_on_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0);

  // R7
  ro_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == REG_LVL || addr_i == REG_NONE))
      |=> ($stable(pin_oe_o) && $stable(pin_out_o | pin_pu_o)));

  // R7
  unused_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_NONE) |-> (rdata_o == '0));

  if (SYNC_STAGES == 2) begin : g_sync_chk
    // R6
    lvl_latency_chk: assert property (@(posedge clk_i)
      disable iff (!rst_ni || warm_q < 2'd2)
      (addr_i == REG_LVL) |-> (rdata_o == $past(pin_i, 2)));
  end
endmodule

bind gpio_tri_port gpio_tri_port_chk #(
  .PIN_W       (PIN_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pin_i     (pin_i),
  .pin_oe_o  (pin_oe_o),
  .pin_out_o (pin_out_o),
  .pin_pu_o  (pin_pu_o)
);

// File: tb/tb_gpio_tri_port.sv
module tb_gpio_tri_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] pin_i = '0;
  logic [7:0] pin_oe_o, pin_out_o, pin_pu_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_tri_port dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pin_i     (pin_i),
    .pin_oe_o  (pin_oe_o),
    .pin_out_o (pin_out_o),
    .pin_pu_o  (pin_pu_o)
  );

  // {addr, we, wdata, pin, exp_rdata, exp_oe, exp_out, exp_pu}
  localparam int NV = 11;
  localparam logic [50:0] VEC [NV] = '{
    {2'd0, 1'b1, 8'hF0, 8'h00, 8'hF0, 8'hF0, 8'h00, 8'h00}, // R2 direction write
    {2'd1, 1'b1, 8'hAA, 8'h5A, 8'hAA, 8'hF0, 8'hA0, 8'h0A}, // R3 R4 R5 mixed pins
    {2'd2, 1'b0, 8'h00, 8'h5A, 8'h5A, 8'hF0, 8'hA0, 8'h0A}, // R6 level read
    {2'd1, 1'b0, 8'h00, 8'h00, 8'hAA, 8'hF0, 8'hA0, 8'h0A}, // R3 latch, not pins
    {2'd2, 1'b1, 8'hFF, 8'h00, 8'h00, 8'hF0, 8'hA0, 8'h0A}, // R7 write to level
    {2'd3, 1'b1, 8'h55, 8'h3C, 8'h00, 8'hF0, 8'hA0, 8'h0A}, // R7 unused address
    {2'd2, 1'b0, 8'h00, 8'h3C, 8'h3C, 8'hF0, 8'hA0, 8'h0A}, // R6
    {2'd0, 1'b1, 8'h0F, 8'h3C, 8'h0F, 8'h0F, 8'h0A, 8'hA0}, // R8 per-pin swap
    {2'd0, 1'b1, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hAA}, // R5 all inputs
    {2'd1, 1'b1, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00}, // R5 tri-state
    {2'd2, 1'b0, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00}  // R6
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic [1:0] a, input logic w, input logic [7:0] d,
                      input logic [7:0] p);
    addr_i = a; we_i = w; wdata_i = d; pin_i = p;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic pads(input string req, input logic [7:0] oe,
                      input logic [7:0] o, input logic [7:0] pu);
    chk(req, "oe", pin_oe_o, oe);
    chk(req, "out", pin_out_o, o);
    chk(req, "pu", pin_pu_o, pu);
  endtask

  initial begin
    logic [7:0] rd;
    #2;
    // R1 during reset
    pads("R1", 8'h00, 8'h00, 8'h00);
    addr_i = 2'd0; #1 chk("R1", "dir read", rdata_o, 8'h00);
    addr_i = 2'd1; #1 chk("R1", "lat read", rdata_o, 8'h00);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    pads("R1", 8'h00, 8'h00, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = VEC[i];
      step(v[50:49], v[48], v[47:40], v[39:32]);
      chk($sformatf("R%0d", (v[50:49] == 2'd2) ? 6 : 3), $sformatf("vec %0d rdata", i),
          rdata_o, v[31:24]);
      pads("R4/R5", v[23:16], v[15:8], v[7:0]);
    end

    // R6: two-edge latency
    step(2'd2, 1'b0, 8'h00, 8'h81);
    chk("R6", "one edge", rdata_o, 8'hFF);
    step(2'd2, 1'b0, 8'h00, 8'h81);
    chk("R6", "two edges", rdata_o, 8'h81);

    // R9: read-modify-write with low inputs keeps pull-ups
    step(2'd0, 1'b1, 8'h0F, 8'h00);
    step(2'd1, 1'b1, 8'hF3, 8'h00);
    pads("R9", 8'h0F, 8'h03, 8'hF0);
    addr_i = 2'd1; #1 rd = rdata_o;
    chk("R9", "latch read", rd, 8'hF3);
    step(2'd1, 1'b1, rd | 8'h04, 8'h00);
    pads("R9", 8'h0F, 8'h07, 8'hF0);

    // R7: writes to level and unused address leave state intact
    step(2'd2, 1'b1, 8'h00, 8'h00);
    step(2'd3, 1'b1, 8'hFF, 8'h00);
    chk("R7", "unused read", rdata_o, 8'h00);
    pads("R7", 8'h0F, 8'h07, 8'hF0);

    // R8: single-pin direction flip
    step(2'd0, 1'b1, 8'h8F, 8'h00);
    pads("R8", 8'h8F, 8'h87, 8'h70);

    // R1: mid-run asynchronous reset
    #1 rst_ni = 1'b0;
    #1 pads("R1", 8'h00, 8'h00, 8'h00);
    addr_i = 2'd1; #1 chk("R1", "lat after reset", rdata_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule